// File: doc/BRIEF.md
# LED Blink and Breathing Modulator

This block sits beside the PWM generator of an LED matrix driver and supplies two global brightness controls. The first is a blink gate: a square wave at a fixed 50% duty whose half-period is a 3-bit code times a base number of timebase ticks. When blinking is enabled, the gate blanks every LED whose own blink-select bit is set, and only those LEDs. The second is a breathing ramp. It runs only when the displayed frame changes. The 8-bit intensity scale fades linearly from full to zero over the fade-out time, then holds at zero for the dark time. The block then signals the frame swap and fades back up over the fade-in time.

The three breathing times are powers of two of a base tick count, selected by 3-bit codes. A tick input advances all timing, so the block runs from any slow timebase. The PWM value of the LED being scanned is presented on `pwm_in`. The block returns that value scaled by the intensity and gated by blink on `pwm_out`.

Top module: `blink_breath_engine`

## Requirements
- R1: With blink enabled and a nonzero code C, the blink gate is 1 (lit) for the first C*BLINK_HALF_TICKS ticks after enable and then toggles after every further C*BLINK_HALF_TICKS ticks. Disabling blink forces the gate to 1 and restarts the count.
- R2: A blink code of 0 keeps the blink gate at 1 whatever the tick input does.
- R3: An LED is blanked (`led_visible`=0, `pwm_out`=0) only when blink is enabled, its `led_blink_sel` is 1 and the gate is 0. With blinking disabled or `led_blink_sel`=0, blinking has no effect on the LED.
- R4: `pwm_out` = (`pwm_in` * (scale+1)) >> 8 for a visible LED, so scale 255 passes `pwm_in` unchanged and `pwm_out` never exceeds `pwm_in`.
- R5: With breathing enabled, a frame-change strobe starts a fade-out of D = 2^(FADE_LOG2+fade_out_code) ticks. After k ticks the scale is 255 - floor(255*k/D).
- R6: The fade-out is followed by a dark phase of 2^(DARK_LOG2+dark_code) ticks at scale 0. At its end `frame_swap` pulses high for exactly one cycle.
- R7: After the swap, the scale equals floor(255*k/D) after k ticks of a fade-in with D = 2^(FADE_LOG2+fade_in_code). When the fade-in completes, the scale returns to 255.
- R8: With breathing disabled, a frame-change strobe gives a `frame_swap` pulse in the next cycle and the scale stays 255.
- R9: A frame-change strobe that arrives while a breathing sequence runs is held. A new sequence starts one cycle after the current one returns to idle. Strobes that arrive together merge into one.
- R10: After reset, the scale is 255, the blink gate is 1 and `frame_swap` is 0.
- R11: While `tick` is 0, neither the blink gate nor the breathing scale advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase strobe; one step of all timing |
| blink_en | input | 1 | Global blink enable |
| blink_code | input | 3 | Blink half-period code, 0 = always lit |
| led_blink_sel | input | 1 | Blink-select bit of the LED being scanned |
| breath_en | input | 1 | Breathing enable, sampled when a sequence starts |
| fade_out_code | input | 3 | Exponent code of the fade-out time |
| fade_in_code | input | 3 | Exponent code of the fade-in time |
| dark_code | input | 3 | Exponent code of the dark time |
| frame_change | input | 1 | Request to switch the displayed frame |
| pwm_in | input | 8 | PWM value of the LED being scanned |
| blink_gate | output | 1 | Blink square wave, 1 = lit phase |
| led_visible | output | 1 | LED not blanked by blink |
| scale | output | 8 | Global intensity scale |
| frame_swap | output | 1 | One-cycle pulse: display the new frame now |
| pwm_out | output | 8 | PWM value after blink gating and scaling |

## Verification
The collision under test is a frame-change strobe that lands in the same cycle as the fade-in finishes and the sequencer returns to idle. The bench raises the strobe so that it is sampled on exactly that edge. The held request must then start a fresh fade-out one cycle later. The bench judges this by the scale falling again and by a second `frame_swap` at the cycle predicted from the fade and dark lengths. A second overlap, a blink-gated LED during a fade, is judged at `pwm_out`, which must read 0 whatever the scale.

// File: rtl/blink_breath_engine.sv
module blink_breath_engine #(
  parameter int BLINK_HALF_TICKS = 3,
  parameter int FADE_LOG2 = 2,
  parameter int DARK_LOG2 = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       blink_en,
  input  logic [2:0] blink_code,
  input  logic       led_blink_sel,
  input  logic       breath_en,
  input  logic [2:0] fade_out_code,
  input  logic [2:0] fade_in_code,
  input  logic [2:0] dark_code,
  input  logic       frame_change,
  input  logic [7:0] pwm_in,
  output logic       blink_gate,
  output logic       led_visible,
  output logic [7:0] scale,
  output logic       frame_swap,
  output logic [7:0] pwm_out
);
  localparam int BCW = $clog2(7 * BLINK_HALF_TICKS + 1);
  localparam int CW  = ((FADE_LOG2 > DARK_LOG2) ? FADE_LOG2 : DARK_LOG2) + 8;

  typedef enum logic [1:0] {S_IDLE, S_FADE_OUT, S_DARK, S_FADE_IN} bstate_t;

  // blink square wave
  logic [BCW-1:0] bcnt;
  logic [BCW-1:0] half_len;
  logic           wave;

  assign half_len = BCW'(blink_code) * BCW'(BLINK_HALF_TICKS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt <= '0;
      wave <= 1'b1;
    end else if (!blink_en || blink_code == 3'd0) begin
      bcnt <= '0;
      wave <= 1'b1;
    end else if (tick) begin
      if (bcnt + BCW'(1) >= half_len) begin
        bcnt <= '0;
        wave <= ~wave;
      end else begin
        bcnt <= bcnt + BCW'(1);
      end
    end
  end

  assign blink_gate  = wave;
  assign led_visible = !(led_blink_sel && !wave);

  // breathing sequencer
  bstate_t       st;
  logic [CW-1:0] el;
  logic          pending;
  logic          swap_q;
  logic [4:0]    sh;
  logic [CW-1:0] dur;
  logic [CW+7:0] prod;
  logic [CW+7:0] ramp;
  logic [7:0]    ramp8;

  always_comb begin
    case (st)
      S_FADE_OUT: sh = 5'(FADE_LOG2) + 5'(fade_out_code);
      S_DARK:     sh = 5'(DARK_LOG2) + 5'(dark_code);
      S_FADE_IN:  sh = 5'(FADE_LOG2) + 5'(fade_in_code);
      default:    sh = 5'(FADE_LOG2);
    endcase
  end

  assign dur   = CW'(1) << sh;
  assign prod  = {8'd0, el} * (CW+8)'(255);
  assign ramp  = prod >> sh;
  assign ramp8 = (ramp > (CW+8)'(255)) ? 8'd255 : ramp[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      el      <= '0;
      pending <= 1'b0;
      swap_q  <= 1'b0;
    end else begin
      swap_q <= 1'b0;
      if (st == S_IDLE) begin
        if (frame_change || pending) begin
          pending <= 1'b0;
          el      <= '0;
          if (breath_en) st <= S_FADE_OUT;
          else swap_q <= 1'b1;
        end
      end else begin
        if (frame_change) pending <= 1'b1;
        if (tick) begin
          if (el + CW'(1) >= dur) begin
            el <= '0;
            case (st)
              S_FADE_OUT: st <= S_DARK;
              S_DARK: begin
                st     <= S_FADE_IN;
                swap_q <= 1'b1;
              end
              default: st <= S_IDLE;
            endcase
          end else begin
            el <= el + CW'(1);
          end
        end
      end
    end
  end

  always_comb begin
    case (st)
      S_FADE_OUT: scale = 8'd255 - ramp8;
      S_DARK:     scale = 8'd0;
      S_FADE_IN:  scale = ramp8;
      default:    scale = 8'd255;
    endcase
  end

  assign frame_swap = swap_q;

  logic [16:0] pwm_prod;
  assign pwm_prod = {9'd0, pwm_in} * ({9'd0, scale} + 17'd1);
  assign pwm_out  = led_visible ? pwm_prod[15:8] : 8'd0;

  // checks
  assert_wave_holds_without_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(tick) && $past(blink_en) && $past(blink_code) != 3'd0) |-> $stable(wave));

  assert_fade_out_descends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FADE_OUT && $past(st) == S_FADE_OUT && $stable(fade_out_code)) |-> scale <= $past(scale));

  assert_fade_in_rises_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FADE_IN && $past(st) == S_FADE_IN && $stable(fade_in_code)) |-> scale >= $past(scale));

  assert_pwm_not_boosted_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_out <= pwm_in);

  assert_swap_single_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_swap && !frame_change) |=> !frame_swap);
endmodule

// File: tb/test_blink_breath_engine.sv
module test_blink_breath_engine;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       blink_en = 1'b0;
  logic [2:0] blink_code = 3'd0;
  logic       led_blink_sel = 1'b0;
  logic       breath_en = 1'b0;
  logic [2:0] fade_out_code = 3'd0;
  logic [2:0] fade_in_code = 3'd0;
  logic [2:0] dark_code = 3'd0;
  logic       frame_change = 1'b0;
  logic [7:0] pwm_in = 8'd0;
  logic       blink_gate, led_visible, frame_swap;
  logic [7:0] scale, pwm_out;

  int tests = 0;
  int failed = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  blink_breath_engine i_blink_breath_engine (
    .clk(clk), .rst_n(rst_n), .tick(tick), .blink_en(blink_en),
    .blink_code(blink_code), .led_blink_sel(led_blink_sel),
    .breath_en(breath_en), .fade_out_code(fade_out_code),
    .fade_in_code(fade_in_code), .dark_code(dark_code),
    .frame_change(frame_change), .pwm_in(pwm_in),
    .blink_gate(blink_gate), .led_visible(led_visible), .scale(scale),
    .frame_swap(frame_swap), .pwm_out(pwm_out)
  );

  // {blink_en, blink_code, led_blink_sel, pwm_in, ticks, expected pwm_out}, half period = code*3 ticks
  localparam logic [28:0] VEC [12] = '{
    {1'b0, 3'd3, 1'b1, 8'd200, 8'd10, 8'd200},
    {1'b1, 3'd1, 1'b1, 8'd200, 8'd2,  8'd200},
    {1'b1, 3'd1, 1'b1, 8'd200, 8'd3,  8'd0},
    {1'b1, 3'd1, 1'b0, 8'd200, 8'd3,  8'd200},
    {1'b1, 3'd1, 1'b1, 8'd77,  8'd6,  8'd77},
    {1'b1, 3'd0, 1'b1, 8'd90,  8'd5,  8'd90},
    {1'b1, 3'd2, 1'b1, 8'd10,  8'd5,  8'd10},
    {1'b1, 3'd2, 1'b1, 8'd10,  8'd6,  8'd0},
    {1'b1, 3'd7, 1'b1, 8'd255, 8'd20, 8'd255},
    {1'b1, 3'd7, 1'b1, 8'd255, 8'd21, 8'd0},
    {1'b1, 3'd1, 1'b1, 8'd0,   8'd0,  8'd0},
    {1'b1, 3'd1, 1'b1, 8'd200, 8'd4,  8'd0}
  };

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // strobe one frame change; returns at the falling edge after the sampling edge
  task automatic strobe;
    @(negedge clk) frame_change = 1'b1;
    @(negedge clk) frame_change = 1'b0;
    #1;
  endtask

  task automatic step;
    @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failed++;
      $display("FAIL watchdog: got 0 expected 1 (run completion)");
      $display("  [TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end

  initial begin
    pwm_in = 8'd123;
    repeat (3) @(negedge clk);
    #1;
    // R10 reset state
    check("R10 scale at reset", scale, 255);
    check("R10 gate at reset", blink_gate, 1);
    check("R10 swap at reset", frame_swap, 0);
    @(negedge clk) rst_n = 1'b1;
    #1;
    check("R4 full scale passes pwm", pwm_out, 123);

    // R1 R2 R3 blink vectors
    for (int i = 0; i < 12; i++) begin
      @(negedge clk) blink_en = 1'b0;
      @(negedge clk);
      blink_en      = VEC[i][28];
      blink_code    = VEC[i][27:25];
      led_blink_sel = VEC[i][24];
      pwm_in        = VEC[i][23:16];
      tick          = (VEC[i][15:8] != 8'd0);
      for (int t = 0; t < int'(VEC[i][15:8]); t++) @(negedge clk);
      tick = 1'b0;
      #1;
      check($sformatf("R1/R2/R3 blink vector %0d", i), pwm_out, int'(VEC[i][7:0]));
    end

    // R11 blink holds without tick
    @(negedge clk) blink_en = 1'b0;
    @(negedge clk) blink_en = 1'b1; blink_code = 3'd1; tick = 1'b1;
    repeat (3) @(negedge clk);
    tick = 1'b0;
    repeat (10) @(negedge clk);
    #1;
    check("R11 blink gate frozen without tick", blink_gate, 0);
    blink_en = 1'b0;

    // R5 R6 R7 breathing, all codes 0: fade 4, dark 2, fade-in 4 ticks
    breath_en = 1'b1; tick = 1'b1; pwm_in = 8'd200;
    strobe();
    begin
      int exp_s [11] = '{255, 192, 128, 64, 0, 0, 0, 63, 127, 191, 255};
      for (int k = 0; k < 11; k++) begin
        check($sformatf("R5/R6/R7 scale step %0d", k), scale, exp_s[k]);
        check($sformatf("R6 swap step %0d", k), frame_swap, (k == 6) ? 1 : 0);
        if (k == 2) check("R4 scaled pwm at 128", pwm_out, 100);
        step();
      end
    end

    // R5 R6 R7 longer codes: fade-out 8, dark 4, fade-in 4
    fade_out_code = 3'd1; dark_code = 3'd1;
    strobe();
    for (int k = 0; k < 17; k++) begin
      if (k == 4)  check("R5 fade-out mid scale", scale, 128);
      if (k == 11) check("R6 no swap before dark end", frame_swap, 0);
      if (k == 12) check("R6 swap after dark end", frame_swap, 1);
      if (k == 15) check("R7 fade-in last step", scale, 191);
      if (k == 16) check("R7 back to full", scale, 255);
      step();
    end
    fade_out_code = 3'd0; dark_code = 3'd0;

    // R9 strobe sampled on the edge the fade-in completes
    strobe();
    for (int k = 0; k < 19; k++) begin
      if (k == 9) frame_change = 1'b1;
      if (k == 10) begin
        frame_change = 1'b0;
        check("R9 idle at completion edge", scale, 255);
      end
      if (k == 11) check("R9 held request restarts fade", scale, 255);
      if (k == 12) check("R9 second fade descending", scale, 192);
      if (k == 17) check("R9 second swap", frame_swap, 1);
      step();
    end
    repeat (10) step();

    // R3 blink blanks during a fade
    blink_en = 1'b1; blink_code = 3'd1; led_blink_sel = 1'b1;
    strobe();
    step(); step();
    check("R3 blanked during fade", pwm_out, 0);
    blink_en = 1'b0;
    repeat (15) step();

    // R11 breathing holds without tick
    strobe();
    step(); step();
    tick = 1'b0;
    repeat (4) step();
    check("R11 scale frozen without tick", scale, 128);
    tick = 1'b1;
    repeat (15) step();

    // R8 breathing disabled
    breath_en = 1'b0;
    strobe();
    check("R8 immediate swap", frame_swap, 1);
    check("R8 scale stays full", scale, 255);
    step();
    check("R8 swap is one cycle", frame_swap, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule